// File: doc/BRIEF.md
# XGMII Transmit Lane Framer

This block sits between a MAC-side octet stream and a four-lane XGMII transmit path. Each clock the MAC offers one column of four octets together with strobes that mark the first column of a frame, the last column, which octets of the last column are valid, and which lanes must be forced to an Error code. The framer emits one registered 32-bit data word and a 4-bit control nibble per clock. Octet `i` of a column is carried on bits `[8i+7:8i]` with control bit `i`. The output lags the input by exactly one clock.

The MAC sends the full frame starting with the preamble. The first column is four preamble octets (0x55), and the second column is three preamble octets followed by the SFD (0xD5) on lane 3. The framer overwrites the lane-0 preamble octet of the first column with a Start control character. It places a Terminate right after the last valid octet and fills every unused lane with Idle. A two-bit link status input can replace frame traffic with continuous Remote Fault ordered sets (status Local Fault) or with continuous Idle (status Remote Fault). A status change is only adopted while no frame is in progress.

Top module: `xgmiiTxFramer`

## Requirements
- R1: Out of reset, and in every column with no frame activity under status OK, all four lanes carry 0x07 with all four control bits set.
- R2: A column offered with `macValid` and `macStart` while idle and status OK leaves the framer with 0xFB and control bit 0 set on lane 0, and the MAC octets of lanes 1..3 as data with their control bits clear. The output appears one clock after the input.
- R3: Preamble, SFD and payload octets of the columns after the start column pass unchanged to their own lanes with control bits clear. Octets on lanes that are not valid in the last column never appear.
- R4: In the last column (`macEnd`), `macKeep` is a contiguous mask from lane 0 (0001, 0011, 0111 or 1111). With k valid octets (k<4), lane k carries 0xFD with its control bit set, and lanes above it carry Idle. With k=4, the next column is 0xFD on lane 0 with Idle on lanes 1..3, and all control bits are set.
- R5: Each bit `macErr[i]` set on a column replaces lane i with 0xFE and control bit set, but only where that lane holds Start or a frame octet. A Terminate or Idle lane is never replaced.
- R6: With `faultStatus` 2'b01 (Local Fault) adopted, every column is 0x9C on lane 0, 0x00 on lanes 1 and 2 and 0x02 on lane 3, with control nibble 4'b0001. Frames offered are discarded.
- R7: With `faultStatus` 2'b10 (Remote Fault) adopted, every column is Idle and frames offered are discarded. Codes 2'b00 and 2'b11 both mean OK.
- R8: The status is adopted in the same clock only when no frame is being sent, no Terminate is pending and no discarded frame is still open. A change during a frame takes effect in the column after the one that carries the Terminate. A change during a discarded frame takes effect after that frame's last column.
- R9: A clock without `macValid` inside an open frame drives 0xFE with control set on all four lanes, and the frame stays open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rstN | input | 1 | Active-low synchronous reset |
| macValid | input | 1 | Column of frame octets present |
| macStart | input | 1 | First column of a frame (preamble) |
| macEnd | input | 1 | Last column of a frame |
| macKeep | input | 4 | Valid octets of the last column, contiguous from lane 0 |
| macErr | input | 4 | Per-lane Error request |
| macData | input | 32 | Four frame octets, lane i on bits [8i+7:8i] |
| faultStatus | input | 2 | Link status: 00/11 OK, 01 Local Fault, 10 Remote Fault |
| txData | output | 32 | XGMII transmit data |
| txCtrl | output | 4 | XGMII transmit control, bit i for lane i |

## Verification
The bench sweeps frame lengths of 1 to 16 payload octets, so the Terminate lands on every lane and the all-valid last column needs its extra Terminate column. A design that miscounts valid octets would put the Terminate on the wrong lane, leak garbage octets, or drop the extra column. Error masks are swept over the last column and applied to the start column. A design that errors Terminate or Idle lanes, or fails to override Start, shows a wrong lane value. Status changes are driven in the middle of sent and discarded frames, and the bench expects the switch exactly one column after the Terminate or the discarded frame's end. A framer that adopts the status early would cut a frame in half, and one that adopts it late would emit stale Idle or fault columns. An underrun inside a frame must produce an all-Error column instead of silently continuing.

// File: rtl/xgmiiTxPkg.sv
package xgmiiTxPkg;
  localparam int LANES      = 4;
  localparam int OCT_W      = 8;
  localparam int COL_W      = LANES * OCT_W;
  localparam int LANE_IDX_W = $clog2(LANES);

  localparam logic [OCT_W-1:0] CH_IDLE  = 8'h07;
  localparam logic [OCT_W-1:0] CH_START = 8'hFB;
  localparam logic [OCT_W-1:0] CH_TERM  = 8'hFD;
  localparam logic [OCT_W-1:0] CH_ERR   = 8'hFE;
  localparam logic [OCT_W-1:0] CH_SEQ   = 8'h9C;
  localparam logic [OCT_W-1:0] RF_CODE  = 8'h02;

  typedef enum logic [1:0] {
    LINK_OK     = 2'b00,
    LINK_LOCAL  = 2'b01,
    LINK_REMOTE = 2'b10
  } linkSt_e;

  typedef enum logic [2:0] {
    COL_IDLE,
    COL_FAULT,
    COL_START,
    COL_DATA,
    COL_TERM,
    COL_UNDER
  } colKind_e;

  typedef struct packed {
    colKind_e                kind;
    logic [LANES-1:0]        dataLanes;
    logic [LANES-1:0]        errLanes;
    logic                    termHere;
    logic [LANE_IDX_W-1:0]   termLane;
  } colCmd_t;
endpackage

// File: rtl/xgmiiTxCtrl.sv
module xgmiiTxCtrl
  import xgmiiTxPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             macValid,
  input  logic             macStart,
  input  logic             macEnd,
  input  logic [LANES-1:0] macKeep,
  input  logic [LANES-1:0] macErr,
  input  logic [1:0]       faultStatus,
  output colCmd_t          cmd
);
  localparam logic [LANE_IDX_W:0] FULL_CNT = (LANE_IDX_W+1)'(LANES);

  logic    frameOpen, dropOpen, termPend;
  logic    frameOpenN, dropOpenN, termPendN;
  linkSt_e linkReg, linkIn, linkNow;
  logic    quiet;
  logic [LANE_IDX_W:0] keepCnt;

  always_comb begin
    unique case (faultStatus)
      2'b01:   linkIn = LINK_LOCAL;
      2'b10:   linkIn = LINK_REMOTE;
      default: linkIn = LINK_OK;
    endcase
  end

  // status may only move between frames
  assign quiet   = !frameOpen && !dropOpen && !termPend;
  assign linkNow = quiet ? linkIn : linkReg;

  always_comb begin
    keepCnt = '0;
    for (int i = 0; i < LANES; i++)
      keepCnt = keepCnt + (LANE_IDX_W+1)'(macKeep[i]);
  end

  always_comb begin
    cmd.kind      = (linkNow == LINK_LOCAL) ? COL_FAULT : COL_IDLE;
    cmd.dataLanes = '0;
    cmd.errLanes  = '0;
    cmd.termHere  = 1'b0;
    cmd.termLane  = '0;
    frameOpenN    = frameOpen;
    dropOpenN     = dropOpen;
    termPendN     = 1'b0;
    if (termPend) begin
      cmd.kind     = COL_TERM;
      cmd.termHere = 1'b1;
    end else if (frameOpen) begin
      if (!macValid) begin
        cmd.kind = COL_UNDER;
      end else begin
        cmd.kind = COL_DATA;
        if (macEnd) begin
          cmd.dataLanes = macKeep;
          frameOpenN    = 1'b0;
          if (keepCnt == FULL_CNT) begin
            termPendN = 1'b1;
          end else begin
            cmd.termHere = 1'b1;
            cmd.termLane = keepCnt[LANE_IDX_W-1:0];
          end
        end else begin
          cmd.dataLanes = '1;
        end
        cmd.errLanes = macErr & cmd.dataLanes;
      end
    end else if (dropOpen) begin
      if (macValid && macEnd) dropOpenN = 1'b0;
    end else if (macValid && macStart) begin
      if (linkNow == LINK_OK) begin
        cmd.kind      = COL_START;
        cmd.dataLanes = '1;
        cmd.errLanes  = macErr;
        frameOpenN    = 1'b1;
      end else begin
        dropOpenN = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameOpen <= 1'b0;
      dropOpen  <= 1'b0;
      termPend  <= 1'b0;
      linkReg   <= LINK_OK;
    end else begin
      frameOpen <= frameOpenN;
      dropOpen  <= dropOpenN;
      termPend  <= termPendN;
      linkReg   <= linkNow;
    end
  end

  // R8: adopted status is frozen while a frame or its Terminate is in flight
  a_r8_status_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (frameOpen || dropOpen || termPend) |=> linkReg == $past(linkReg));

  // R4: a deferred Terminate occupies exactly one column
  a_r4_single_pending: assert property (@(posedge clk) disable iff (!rstN)
    termPend |=> !termPend);
endmodule

// File: rtl/xgmiiTxDatapath.sv
module xgmiiTxDatapath
  import xgmiiTxPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  colCmd_t          cmd,
  input  logic [COL_W-1:0] macData,
  output logic [COL_W-1:0] txData,
  output logic [LANES-1:0] txCtrl
);
  logic [COL_W-1:0] nextData;
  logic [LANES-1:0] nextCtrl;
  logic [LANES-1:0] termHit, startHit;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [OCT_W-1:0] oct;
    logic             ctl;
    logic [OCT_W-1:0] inOct;
    assign inOct = macData[i*OCT_W +: OCT_W];

    always_comb begin
      oct = CH_IDLE;
      ctl = 1'b1;
      unique case (cmd.kind)
        COL_FAULT: begin
          if (i == 0) begin
            oct = CH_SEQ;
            ctl = 1'b1;
          end else begin
            oct = (i == LANES-1) ? RF_CODE : '0;
            ctl = 1'b0;
          end
        end
        COL_START: begin
          oct = (i == 0) ? CH_START : inOct;
          ctl = (i == 0);
        end
        COL_DATA, COL_TERM: begin
          if (cmd.dataLanes[i]) begin
            oct = inOct;
            ctl = 1'b0;
          end else if (cmd.termHere && cmd.termLane == LANE_IDX_W'(i)) begin
            oct = CH_TERM;
          end
        end
        COL_UNDER: oct = CH_ERR;
        default: oct = CH_IDLE;
      endcase
      if (cmd.errLanes[i]) begin
        oct = CH_ERR;
        ctl = 1'b1;
      end
    end

    assign nextData[i*OCT_W +: OCT_W] = oct;
    assign nextCtrl[i] = ctl;
    assign termHit[i]  = txCtrl[i] && (txData[i*OCT_W +: OCT_W] == CH_TERM);
    assign startHit[i] = txCtrl[i] && (txData[i*OCT_W +: OCT_W] == CH_START);

    // R5: a requested Error lands on its own lane one clock later
    a_r5_err_lane: assert property (@(posedge clk) disable iff (!rstN)
      cmd.errLanes[i] |=> txCtrl[i] && txData[i*OCT_W +: OCT_W] == CH_ERR);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txData <= {LANES{CH_IDLE}};
      txCtrl <= '1;
    end else begin
      txData <= nextData;
      txCtrl <= nextCtrl;
    end
  end

  // R4: at most one Terminate per column
  a_r4_one_term: assert property (@(posedge clk) disable iff (!rstN)
    $countones(termHit) <= 1);

  // R2: Start never leaves lane 0
  a_r2_start_lane0: assert property (@(posedge clk) disable iff (!rstN)
    startHit[LANES-1:1] == '0);

  // R6: a Sequence on lane 0 is always a full Remote Fault column
  a_r6_fault_column: assert property (@(posedge clk) disable iff (!rstN)
    (txCtrl[0] && txData[OCT_W-1:0] == CH_SEQ) |->
      (txCtrl == 4'b0001 && txData[COL_W-1:OCT_W] == 24'h020000));
endmodule

// File: rtl/xgmiiTxFramer.sv
module xgmiiTxFramer
  import xgmiiTxPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             macValid,
  input  logic             macStart,
  input  logic             macEnd,
  input  logic [LANES-1:0] macKeep,
  input  logic [LANES-1:0] macErr,
  input  logic [COL_W-1:0] macData,
  input  logic [1:0]       faultStatus,
  output logic [COL_W-1:0] txData,
  output logic [LANES-1:0] txCtrl
);
  colCmd_t cmd;

  xgmiiTxCtrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .macValid    (macValid),
    .macStart    (macStart),
    .macEnd      (macEnd),
    .macKeep     (macKeep),
    .macErr      (macErr),
    .faultStatus (faultStatus),
    .cmd         (cmd)
  );

  xgmiiTxDatapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .macData (macData),
    .txData  (txData),
    .txCtrl  (txCtrl)
  );
endmodule

// File: tb/xgmiiTxFramer_test.sv
module xgmiiTxFramer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        macValid = 1'b0, macStart = 1'b0, macEnd = 1'b0;
  logic [3:0]  macKeep = '0, macErr = '0;
  logic [31:0] macData = '0;
  logic [1:0]  faultStatus = 2'b00;
  logic [31:0] txData;
  logic [3:0]  txCtrl;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  localparam logic [31:0] IDLE_COL = 32'h07070707;
  localparam logic [31:0] RF_COL   = 32'h0200009C;

  xgmiiTxFramer uut (
    .clk(clk), .rstN(rstN), .macValid(macValid), .macStart(macStart),
    .macEnd(macEnd), .macKeep(macKeep), .macErr(macErr), .macData(macData),
    .faultStatus(faultStatus), .txData(txData), .txCtrl(txCtrl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic drive(input logic v, input logic s, input logic e,
                       input logic [3:0] keep, input logic [3:0] err,
                       input logic [31:0] d);
    @(negedge clk);
    macValid = v; macStart = s; macEnd = e;
    macKeep = keep; macErr = err; macData = d;
    @(posedge clk);
    #1;
  endtask

  task automatic idleDrive();
    drive(1'b0, 1'b0, 1'b0, 4'h0, 4'h0, 32'hDEADBEEF);
  endtask

  task automatic check(input string req, input logic [31:0] expD,
                       input logic [3:0] expC);
    total++;
    if (txData !== expD || txCtrl !== expC) begin
      bad++;
      $display("FAIL %s: got %h/%b expected %h/%b", req, txData, txCtrl, expD, expC);
    end
  endtask

  function automatic logic [7:0] octetOf(int n, int k);
    return 8'((n * 17 + k * 7 + 33) & 255);
  endfunction

  // full frame with expected columns; faultAt selects a data column where
  // the status input changes to newFault (R8)
  task automatic sendFrame(input int n, input logic [3:0] startErr,
                           input logic [3:0] lastErr, input int faultAt,
                           input logic [1:0] newFault);
    int cols;
    logic [31:0] expD;
    logic [3:0]  expC;
    cols = (n + 3) / 4;
    drive(1'b1, 1'b1, 1'b0, 4'h0, startErr, 32'h55555555);
    expD = 32'h555555FB; expC = 4'b0001;
    for (int i = 0; i < 4; i++)
      if (startErr[i]) begin expD[i*8 +: 8] = 8'hFE; expC[i] = 1'b1; end
    check(startErr != 0 ? "R5 start column error" : "R2 start column", expD, expC);
    drive(1'b1, 1'b0, 1'b0, 4'h0, 4'h0, 32'hD5555555);
    check("R3 preamble/SFD column", 32'hD5555555, 4'b0000);
    for (int c = 0; c < cols; c++) begin
      bit last;
      int valid;
      logic [31:0] d;
      logic [3:0] err;
      last  = (c == cols - 1);
      valid = last ? n - 4 * c : 4;
      err   = last ? lastErr : 4'h0;
      for (int i = 0; i < 4; i++)
        d[i*8 +: 8] = (i < valid) ? octetOf(n, 4 * c + i) : 8'hFB;
      if (c == faultAt) faultStatus = newFault;
      drive(1'b1, 1'b0, last, last ? 4'((1 << valid) - 1) : 4'hF, err, d);
      for (int i = 0; i < 4; i++) begin
        if (i < valid) begin
          expD[i*8 +: 8] = err[i] ? 8'hFE : d[i*8 +: 8];
          expC[i] = err[i];
        end else if (i == valid) begin
          expD[i*8 +: 8] = 8'hFD; expC[i] = 1'b1;
        end else begin
          expD[i*8 +: 8] = 8'h07; expC[i] = 1'b1;
        end
      end
      check(last ? (err != 0 ? "R5 last column error" : "R4 terminate lane")
                 : "R3 payload column", expD, expC);
    end
    if (n % 4 == 0) begin
      idleDrive();
      check("R4 deferred terminate column", 32'h070707FD, 4'hF);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 idle during reset", IDLE_COL, 4'hF);
    @(negedge clk);
    rstN = 1'b1;
    idleDrive();
    check("R1 idle after reset", IDLE_COL, 4'hF);

    // R3/R4: every length, terminate on every lane
    for (int n = 1; n <= 16; n++) begin
      sendFrame(n, 4'h0, 4'h0, -1, 2'b00);
      idleDrive(); check("R1 idle gap", IDLE_COL, 4'hF);
      idleDrive(); check("R1 idle gap", IDLE_COL, 4'hF);
    end

    // R5: error masks over the last column, and on the start column
    for (int n = 1; n <= 8; n++) begin
      sendFrame(n, 4'h0, 4'((n * 3 + 1) & 15), -1, 2'b00);
      idleDrive(); check("R1 idle after errored frame", IDLE_COL, 4'hF);
      idleDrive();
    end
    sendFrame(5, 4'b0001, 4'h0, -1, 2'b00);
    idleDrive(); idleDrive();
    sendFrame(3, 4'b1010, 4'h0, -1, 2'b00);
    idleDrive(); idleDrive();

    // R6: local fault produces Remote Fault columns
    faultStatus = 2'b01;
    for (int k = 0; k < 3; k++) begin
      idleDrive(); check("R6 fault column", RF_COL, 4'b0001);
    end
    // R6/R8: frame offered under local fault is discarded; OK mid-drop waits
    drive(1'b1, 1'b1, 1'b0, 4'h0, 4'h0, 32'h55555555);
    check("R6 discarded start", RF_COL, 4'b0001);
    faultStatus = 2'b00;
    drive(1'b1, 1'b0, 1'b0, 4'h0, 4'h0, 32'hD5555555);
    check("R8 status held during discarded frame", RF_COL, 4'b0001);
    drive(1'b1, 1'b0, 1'b1, 4'h3, 4'h0, 32'h00001122);
    check("R8 status held at discarded end", RF_COL, 4'b0001);
    idleDrive(); check("R8 OK adopted after discarded frame", IDLE_COL, 4'hF);

    // R7: remote fault gives idle and discards frames
    faultStatus = 2'b10;
    idleDrive(); check("R7 idle under remote fault", IDLE_COL, 4'hF);
    drive(1'b1, 1'b1, 1'b0, 4'h0, 4'h0, 32'h55555555);
    check("R7 discarded start", IDLE_COL, 4'hF);
    drive(1'b1, 1'b0, 1'b1, 4'hF, 4'h0, 32'hD5555555);
    check("R7 discarded end", IDLE_COL, 4'hF);
    faultStatus = 2'b11;
    idleDrive(); check("R7 code 11 is OK", IDLE_COL, 4'hF);
    faultStatus = 2'b00;
    idleDrive();

    // R8: fault arriving mid-frame waits for the Terminate
    sendFrame(8, 4'h0, 4'h0, 0, 2'b01);
    idleDrive(); check("R8 fault after deferred terminate", RF_COL, 4'b0001);
    faultStatus = 2'b00;
    idleDrive(); check("R8 back to OK", IDLE_COL, 4'hF);
    idleDrive();
    sendFrame(6, 4'h0, 4'h0, 1, 2'b01);
    idleDrive(); check("R8 fault after in-column terminate", RF_COL, 4'b0001);
    faultStatus = 2'b00;
    idleDrive(); idleDrive();

    // R9: underrun inside a frame
    drive(1'b1, 1'b1, 1'b0, 4'h0, 4'h0, 32'h55555555);
    check("R2 start before underrun", 32'h555555FB, 4'b0001);
    idleDrive(); check("R9 underrun column", 32'hFEFEFEFE, 4'hF);
    drive(1'b1, 1'b0, 1'b0, 4'h0, 4'h0, 32'hD5555555);
    check("R9 frame continues after underrun", 32'hD5555555, 4'b0000);
    drive(1'b1, 1'b0, 1'b1, 4'h3, 4'h0, 32'hFBFB4433);
    check("R4 terminate after underrun", 32'h07FD4433, 4'b1100);
    idleDrive(); check("R1 idle after underrun frame", IDLE_COL, 4'hF);

    $display("test done: total=%0d bad=%0d", total, bad);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule